// File: doc/BRIEF.md
# Floating-Point Branch Resolver with Delay Slot

This block settles a floating-point conditional branch in one clock. It receives the address of the branch, the 32-bit branch instruction and the 2-bit floating-point condition code. From these it decides whether the branch is taken and computes the word-displacement target. It also decides whether the instruction in the delay slot that follows the branch is skipped. It registers the two addresses that fetch should use next, together with a taken flag and an annul flag.

The front end drives `br_valid_i` for one cycle per branch. The result appears on the outputs in the following cycle, marked by `res_valid_o`. The result stays on the outputs until the next branch arrives. Two wrapping counters run alongside the result. One counts taken branches and the other counts skipped delay slots.

Top module: `fpbr_resolve`

## Requirements
- R1: The condition is instruction bits [28:25]. Condition 0 is never taken. Condition 8 is always taken, whatever the condition code.
- R2: The condition code is encoded as 0 = equal (E), 1 = less (L), 2 = greater (G) and 3 = unordered (U). The remaining conditions take the branch for these code sets: 1 {L,G,U}, 2 {L,G}, 3 {L,U}, 4 {L}, 5 {G,U}, 6 {G}, 7 {U}, 9 {E}, 10 {E,U}, 11 {E,G}, 12 {E,G,U}, 13 {E,L}, 14 {E,L,U}, 15 {E,L,G}.
- R3: The target is the branch address plus the displacement in bits [21:0], taken as a signed number and multiplied by four, modulo 2^ADDR_W.
- R4: An untaken branch with the annul bit (instruction bit 29) clear gives fetch0 = pc+4, fetch1 = pc+8 and annul = 0.
- R5: An untaken branch with the annul bit set skips the delay slot. It gives fetch0 = pc+8, fetch1 = pc+12 and annul = 1.
- R6: Condition 8 with the annul bit set jumps straight to the target. It gives fetch0 = target, fetch1 = target+4, taken = 1 and annul = 1.
- R7: Every other taken branch runs the delay slot and then goes to the target. This includes a conditional branch taken with the annul bit set. It gives fetch0 = pc+4, fetch1 = target and annul = 0.
- R8: The result is registered. It appears in the cycle after a clock edge that sees `br_valid_i` high, with `res_valid_o` = 1. When the edge sees `br_valid_i` low, `res_valid_o` goes to 0, and the taken flag, the annul flag and both fetch addresses hold their values.
- R9: The taken counter adds one for each resolved taken branch. The annul counter adds one for each skipped delay slot. Both wrap modulo 2^CNT_W, and neither changes on a cycle without `br_valid_i`.
- R10: While reset is held, and right after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | A branch is presented this cycle |
| br_pc_i | input | ADDR_W | Address of the branch |
| br_instr_i | input | 32 | Branch instruction word |
| fcc_i | input | 2 | Floating-point condition code |
| res_valid_o | output | 1 | Result registered from a branch last cycle |
| res_taken_o | output | 1 | The branch was taken |
| res_annul_o | output | 1 | The delay slot is skipped |
| fetch0_o | output | ADDR_W | Next address to execute |
| fetch1_o | output | ADDR_W | Address executed after fetch0 |
| taken_cnt_o | output | CNT_W | Wrapping count of taken branches |
| annul_cnt_o | output | CNT_W | Wrapping count of skipped slots |

## Verification
A branch can be taken and annul its slot in the same cycle only through condition 8 with the annul bit set. In that case both counters step together, and fetch0 moves to the target instead of the slot. The bench provokes this case, and also its neighbours: condition 8 with annul clear, a taken conditional branch with annul set, and an untaken branch with annul set. Each of these asserts exactly one of the two flags. The bench judges each case on both flags, both fetch addresses and both counter deltas. A narrow counter width lets the bench drive both counters through their wrap in the same burst.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;

    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_e;

    localparam int COND_W      = 4;
    localparam int COND_COUNT  = 1 << COND_W;
    localparam int COND_LSB    = 25;
    localparam int ANNUL_POS   = 29;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'd8;

    // Bit k of the mask is set when the branch is taken for code value k.
    function automatic logic [3:0] cond_mask(input logic [COND_W-1:0] c);
        logic [3:0] m;
        case (c)
            4'd0:    m = 4'b0000;
            4'd1:    m = 4'b1110;
            4'd2:    m = 4'b0110;
            4'd3:    m = 4'b1010;
            4'd4:    m = 4'b0010;
            4'd5:    m = 4'b1100;
            4'd6:    m = 4'b0100;
            4'd7:    m = 4'b1000;
            4'd8:    m = 4'b1111;
            4'd9:    m = 4'b0001;
            4'd10:   m = 4'b1001;
            4'd11:   m = 4'b0101;
            4'd12:   m = 4'b1101;
            4'd13:   m = 4'b0011;
            4'd14:   m = 4'b1011;
            default: m = 4'b0111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fpbr_cond_decode.sv
module fpbr_cond_decode
    import fpbr_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [1:0]        fcc_i,
    output logic              take_o
);

    logic [3:0] mask_tbl [COND_COUNT];

    for (genvar c = 0; c < COND_COUNT; c++) begin : g_mask
        assign mask_tbl[c] = cond_mask(COND_W'(c));
    end

    always_comb begin
        take_o = mask_tbl[cond_i][fcc_i];
    end

endmodule

// File: rtl/fpbr_target_gen.sv
module fpbr_target_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 22
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] byte_off;

    always_comb begin
        byte_off = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
        target_o = pc_i + byte_off;
    end

endmodule

// File: rtl/fpbr_fetch_sel.sv
module fpbr_fetch_sel #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              take_i,
    input  logic              annul_bit_i,
    input  logic              always_i,
    output logic [ADDR_W-1:0] fetch0_o,
    output logic [ADDR_W-1:0] fetch1_o,
    output logic              annul_o
);

    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    logic [ADDR_W-1:0] slot_pc, after_slot, after_two, tgt_next;

    always_comb begin
        slot_pc    = pc_i + WORD;
        after_slot = pc_i + (WORD << 1);
        after_two  = pc_i + (WORD << 1) + WORD;
        tgt_next   = target_i + WORD;

        if (!take_i) begin
            if (annul_bit_i) begin
                fetch0_o = after_slot;
                fetch1_o = after_two;
                annul_o  = 1'b1;
            end else begin
                fetch0_o = slot_pc;
                fetch1_o = after_slot;
                annul_o  = 1'b0;
            end
        end else if (always_i && annul_bit_i) begin
            fetch0_o = target_i;
            fetch1_o = tgt_next;
            annul_o  = 1'b1;
        end else begin
            fetch0_o = slot_pc;
            fetch1_o = target_i;
            annul_o  = 1'b0;
        end
    end

endmodule

// File: rtl/fpbr_resolve.sv
module fpbr_resolve
    import fpbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 22,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid_i,
    input  logic [ADDR_W-1:0] br_pc_i,
    input  logic [31:0]       br_instr_i,
    input  logic [1:0]        fcc_i,
    output logic              res_valid_o,
    output logic              res_taken_o,
    output logic              res_annul_o,
    output logic [ADDR_W-1:0] fetch0_o,
    output logic [ADDR_W-1:0] fetch1_o,
    output logic [CNT_W-1:0]  taken_cnt_o,
    output logic [CNT_W-1:0]  annul_cnt_o
);

    typedef struct packed {
        logic              vld;
        logic              taken;
        logic              annul;
        logic [ADDR_W-1:0] f0;
        logic [ADDR_W-1:0] f1;
        logic [CNT_W-1:0]  tcnt;
        logic [CNT_W-1:0]  acnt;
    } state_t;

    state_t st_d, st_q;

    logic [COND_W-1:0] cond_f;
    logic              annul_bit;
    logic [DISP_W-1:0] disp_f;
    logic              take_c, annul_c, always_c;
    logic [ADDR_W-1:0] target_c, f0_c, f1_c;

    assign cond_f    = br_instr_i[COND_LSB +: COND_W];
    assign annul_bit = br_instr_i[ANNUL_POS];
    assign disp_f    = br_instr_i[DISP_W-1:0];
    assign always_c  = (cond_f == COND_ALWAYS);

    fpbr_cond_decode u_dec (
        .cond_i (cond_f),
        .fcc_i  (fcc_i),
        .take_o (take_c)
    );

    fpbr_target_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .pc_i     (br_pc_i),
        .disp_i   (disp_f),
        .target_o (target_c)
    );

    fpbr_fetch_sel #(.ADDR_W(ADDR_W)) u_sel (
        .pc_i        (br_pc_i),
        .target_i    (target_c),
        .take_i      (take_c),
        .annul_bit_i (annul_bit),
        .always_i    (always_c),
        .fetch0_o    (f0_c),
        .fetch1_o    (f1_c),
        .annul_o     (annul_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = br_valid_i;
        if (br_valid_i) begin
            st_d.taken = take_c;
            st_d.annul = annul_c;
            st_d.f0    = f0_c;
            st_d.f1    = f1_c;
            st_d.tcnt  = st_q.tcnt + CNT_W'(take_c);
            st_d.acnt  = st_q.acnt + CNT_W'(annul_c);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.vld;
    assign res_taken_o = st_q.taken;
    assign res_annul_o = st_q.annul;
    assign fetch0_o    = st_q.f0;
    assign fetch1_o    = st_q.f1;
    assign taken_cnt_o = st_q.tcnt;
    assign annul_cnt_o = st_q.acnt;

    // Condition 0 never branches.
    assert_never_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && cond_f == 4'd0) |=> (res_valid_o && !res_taken_o));

    // Condition 8 always branches.
    assert_always_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && cond_f == COND_ALWAYS) |=> (res_valid_o && res_taken_o));

    // An untaken branch fetches two consecutive words.
    assert_untaken_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_taken_o) |-> (fetch1_o == fetch0_o + ADDR_W'(4)));

    // Branch-always with annul: both flags set, target followed by the next word.
    assert_ba_annul_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && always_c && annul_bit) |=>
        (res_taken_o && res_annul_o && fetch1_o == fetch0_o + ADDR_W'(4)));

    // A taken branch steps the taken count by one.
    assert_taken_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && take_c) |=> (taken_cnt_o == $past(taken_cnt_o) + CNT_W'(1)));

    // Idle cycles leave the counters and the result untouched.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid_i |=> (!res_valid_o && $stable(taken_cnt_o) && $stable(annul_cnt_o)
                         && $stable(fetch0_o) && $stable(fetch1_o)));

endmodule

// File: tb/fpbr_resolve_test.sv
module fpbr_resolve_test;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              br_valid_i = 1'b0;
    logic [ADDR_W-1:0] br_pc_i = '0;
    logic [31:0]       br_instr_i = '0;
    logic [1:0]        fcc_i = '0;
    logic              res_valid_o, res_taken_o, res_annul_o;
    logic [ADDR_W-1:0] fetch0_o, fetch1_o;
    logic [CNT_W-1:0]  taken_cnt_o, annul_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [CNT_W-1:0] exp_tc = '0;
    logic [CNT_W-1:0] exp_ac = '0;

    always #5 clk = ~clk;

    fpbr_resolve #(.ADDR_W(ADDR_W), .DISP_W(22), .CNT_W(CNT_W)) uut (
        .clk, .rst_n, .br_valid_i, .br_pc_i, .br_instr_i, .fcc_i,
        .res_valid_o, .res_taken_o, .res_annul_o, .fetch0_o, .fetch1_o,
        .taken_cnt_o, .annul_cnt_o
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic an, input logic [3:0] c, input logic [21:0] d);
        return {2'b00, an, c, 3'b110, d};
    endfunction

    // Condition code: 0 E, 1 L, 2 G, 3 U.
    function automatic logic model_take(input logic [3:0] c, input logic [1:0] f);
        logic e, l, g, u;
        e = (f == 2'd0); l = (f == 2'd1); g = (f == 2'd2); u = (f == 2'd3);
        case (c)
            4'd0:  return 1'b0;
            4'd1:  return l | g | u;
            4'd2:  return l | g;
            4'd3:  return l | u;
            4'd4:  return l;
            4'd5:  return u | g;
            4'd6:  return g;
            4'd7:  return u;
            4'd8:  return 1'b1;
            4'd9:  return e;
            4'd10: return e | u;
            4'd11: return e | g;
            4'd12: return e | g | u;
            4'd13: return e | l;
            4'd14: return e | l | u;
            default: return e | l | g;
        endcase
    endfunction

    // Presents one branch and checks everything the next cycle shows.
    task automatic resolve(input string tag, input logic [31:0] pc, input logic an,
                           input logic [3:0] c, input logic [21:0] d, input logic [1:0] f);
        logic tk, ax;
        logic [31:0] tgt, e0, e1;
        tk  = model_take(c, f);
        tgt = pc + {{8{d[21]}}, d, 2'b00};
        if (!tk) begin
            ax = an;
            e0 = an ? pc + 32'd8 : pc + 32'd4;
            e1 = an ? pc + 32'd12 : pc + 32'd8;
        end else if (c == 4'd8 && an) begin
            ax = 1'b1; e0 = tgt; e1 = tgt + 32'd4;
        end else begin
            ax = 1'b0; e0 = pc + 32'd4; e1 = tgt;
        end
        exp_tc = exp_tc + CNT_W'(tk);
        exp_ac = exp_ac + CNT_W'(ax);
        @(negedge clk);
        br_valid_i = 1'b1; br_pc_i = pc; br_instr_i = mk(an, c, d); fcc_i = f;
        @(posedge clk);
        #2;
        chk({tag, " R8 valid"}, 64'(res_valid_o), 64'd1);
        chk({tag, " R2 taken"}, 64'(res_taken_o), 64'(tk));
        chk({tag, " R5 annul"}, 64'(res_annul_o), 64'(ax));
        chk({tag, " R7 fetch0"}, 64'(fetch0_o), 64'(e0));
        chk({tag, " R3 fetch1"}, 64'(fetch1_o), 64'(e1));
        chk({tag, " R9 taken count"}, 64'(taken_cnt_o), 64'(exp_tc));
        chk({tag, " R9 annul count"}, 64'(annul_cnt_o), 64'(exp_ac));
        @(negedge clk);
        br_valid_i = 1'b0;
    endtask

    task automatic test_reset();
        chk("R10 valid", 64'(res_valid_o), 64'd0);
        chk("R10 taken", 64'(res_taken_o), 64'd0);
        chk("R10 annul", 64'(res_annul_o), 64'd0);
        chk("R10 fetch0", 64'(fetch0_o), 64'd0);
        chk("R10 fetch1", 64'(fetch1_o), 64'd0);
        chk("R10 counts", 64'({taken_cnt_o, annul_cnt_o}), 64'd0);
    endtask

    task automatic test_cond_table();
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 4; f++)
                resolve("R1/R2/R4 table", 32'h0000_4000 + 32'(c * 64), 1'b0, 4'(c), 22'h000010, 2'(f));
    endtask

    task automatic test_untaken_annul();
        resolve("R5 untaken annul L", 32'h0000_8000, 1'b1, 4'd9, 22'h000020, 2'd1);
        resolve("R5 never annul", 32'h0000_8100, 1'b1, 4'd0, 22'h000020, 2'd0);
        resolve("R5 unordered miss", 32'h0000_8200, 1'b1, 4'd15, 22'h3FFFF0, 2'd3);
    endtask

    task automatic test_ba_annul();
        resolve("R6 ba annul", 32'h0001_0000, 1'b1, 4'd8, 22'h000100, 2'd3);
        resolve("R6 ba annul back", 32'h0001_0000, 1'b1, 4'd8, 22'h3FFF00, 2'd0);
    endtask

    task automatic test_taken_slot();
        resolve("R7 ba no annul", 32'h0002_0000, 1'b0, 4'd8, 22'h000040, 2'd2);
        resolve("R7 cond taken annul", 32'h0002_0000, 1'b1, 4'd7, 22'h000040, 2'd3);
        resolve("R7 cond taken annul E", 32'h0002_0400, 1'b1, 4'd13, 22'h3FFFFF, 2'd0);
    endtask

    task automatic test_target_range();
        resolve("R3 disp -1", 32'h0000_1000, 1'b0, 4'd8, 22'h3FFFFF, 2'd0);
        resolve("R3 disp max", 32'h0000_1000, 1'b0, 4'd8, 22'h1FFFFF, 2'd0);
        resolve("R3 disp min", 32'h0100_0000, 1'b0, 4'd8, 22'h200000, 2'd0);
        resolve("R3 addr wrap", 32'hFFFF_FFF0, 1'b0, 4'd8, 22'h000008, 2'd0);
        resolve("R3 disp zero", 32'h0000_2000, 1'b1, 4'd8, 22'h000000, 2'd0);
    endtask

    task automatic test_idle_hold();
        logic [31:0] h0, h1;
        logic [CNT_W-1:0] ht, ha;
        logic hk, hn;
        h0 = fetch0_o; h1 = fetch1_o; ht = taken_cnt_o; ha = annul_cnt_o;
        hk = res_taken_o; hn = res_annul_o;
        @(negedge clk);
        br_instr_i = mk(1'b1, 4'd8, 22'h000444); br_pc_i = 32'h0ABC_0000; fcc_i = 2'd3;
        @(posedge clk); #2;
        @(posedge clk); #2;
        chk("R8 idle valid", 64'(res_valid_o), 64'd0);
        chk("R8 idle flags", 64'({res_taken_o, res_annul_o}), 64'({hk, hn}));
        chk("R8 idle fetch0", 64'(fetch0_o), 64'(h0));
        chk("R8 idle fetch1", 64'(fetch1_o), 64'(h1));
        chk("R9 idle counts", 64'({taken_cnt_o, annul_cnt_o}), 64'({ht, ha}));
    endtask

    task automatic test_counter_wrap();
        for (int i = 0; i < 20; i++)
            resolve("R9 wrap both", 32'h0003_0000, 1'b1, 4'd8, 22'h000004, 2'(i));
        for (int i = 0; i < 18; i++)
            resolve("R9 wrap annul only", 32'h0003_1000, 1'b1, 4'd6, 22'h000004, 2'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        test_reset();
        test_cond_table();
        test_untaken_annul();
        test_ba_annul();
        test_taken_slot();
        test_target_range();
        test_idle_hold();
        test_counter_wrap();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule